// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This block is a real-time counter that runs from a slow clock of about 32 kHz and is read and written from a faster bus clock through a 32-bit register port. A 47-bit counter advances by one on every slow-clock edge. Its upper 32 bits count whole seconds and its lower 15 bits hold the fraction of a second. Software sets a seconds value in an alarm register and enables the alarm. When the seconds field reaches that value, a sticky status flag is set. The flag drives an interrupt line and a wakeup line, and each line has its own enable bit.

All configuration lives on the bus side. The slow domain sees the control bits only after a two-flop synchronizer and one more register, so control readback lags a write by about three slow-clock cycles. The counter is loaded from two staging words, and only while counting is off. Reads of the counter return a complete 47-bit snapshot. A request/acknowledge toggle loop refreshes that snapshot continuously, so each 32-bit word is always coherent. The low and high words may still come from different snapshots.

Top module: `rtc_lp_top`

## Requirements
- R1: After reset, the control, status, counter-high, counter-low and alarm registers all read 0, and both `alarm_irq_o` and `wake_o` are low.
- R2: While counting is enabled, the counter increments once per slow-clock cycle. Counter bits 46:15 are whole seconds, so a fraction of 0x7FF0 rolls into the next second after 16 slow cycles.
- R3: The register at offset 0x20 returns counter bits 31:0. The register at 0x1C returns counter bits 46:32 in its bits 14:0, and its bits 31:15 read 0.
- R4: Control register 0x04 stores enable (bit 0), alarm enable (bit 1) and wakeup enable (bit 3). Its other bits read 0. Readback shows a written value only after slow-domain synchronization: a read issued right after the write still returns the old value, and a read several slow cycles later returns the new one.
- R5: Writes to 0x20 and 0x1C load the counter only while counting is disabled. While counting is enabled, such writes are ignored.
- R6: When the alarm is enabled and counter bits 46:15 equal the 32-bit value in the alarm register (0x24), status bit 0 (0x18) is set.
- R7: Status bit 0 is write-one-to-clear. Writing 0 leaves it set, and writing 0xFFFFFFFF clears it.
- R8: With alarm enable at 0, the seconds count passing the alarm value does not set status bit 0.
- R9: `alarm_irq_o` is high while status bit 0 and control bit 1 are both set. `wake_o` is high while status bit 0 and control bit 3 are both set.
- R10: The register at 0x30 stores and returns a full 32-bit word, such as the initialization value 0x41736166.
- R11: While counting is disabled and no load is pending, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | Slow counting clock |
| rst_i | input | 1 | Synchronous active-high reset, held across several slow-clock cycles |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; data is valid on the following cycle |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| alarm_irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Wakeup request |

## Verification
The hardest condition to reach is an alarm match. Counting up to a seconds boundary from reset would take 32768 slow cycles per second. The bench avoids this by disabling the counter and loading a fraction of 0x7FF0 just below the alarm second. It then programs the alarm and re-enables counting, so the match arrives after a few dozen slow cycles. The same preload, run with the alarm disabled, confirms that the flag stays clear. Writes issued while counting runs, and a read issued straight after a control write, probe the gating and the synchronizer latency.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CNTHI = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CNTLO = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ALARM = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_GLTCH = 8'h30;
  // control bit positions in the bus register
  localparam int BIT_EN   = 0;
  localparam int BIT_ALM  = 1;
  localparam int BIT_WAKE = 3;
  // packed control vector index
  localparam int CI_EN   = 0;
  localparam int CI_ALM  = 1;
  localparam int CI_WAKE = 2;
  localparam int CTRL_N  = 3;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
  import rtc_lp_pkg::*;
#(
  parameter int FRAC_W = 15,
  parameter int SEC_W  = 32,
  localparam int CNT_W = FRAC_W + SEC_W
) (
  input  logic              slow_clk,
  input  logic              rst,
  input  logic [CTRL_N-1:0] ctrl_req,
  input  logic              load_arm,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [SEC_W-1:0]  alarm_sec,
  input  logic              snap_req,
  output logic [CTRL_N-1:0] ctrl_eff,
  output logic [CNT_W-1:0]  snap_val,
  output logic              snap_ack,
  output logic              match_tgl
);
  logic [CTRL_N-1:0] ctrl_s;
  logic              arm_s, req_s;
  logic [CNT_W-1:0]  cnt;
  logic              match, match_q;

  rtc_sync #(.W(CTRL_N)) u_ctrl_sync (.clk(slow_clk), .rst(rst), .d(ctrl_req), .q(ctrl_s));
  rtc_sync #(.W(1))      u_arm_sync  (.clk(slow_clk), .rst(rst), .d(load_arm), .q(arm_s));
  rtc_sync #(.W(1))      u_req_sync  (.clk(slow_clk), .rst(rst), .d(snap_req), .q(req_s));

  always_ff @(posedge slow_clk) begin
    if (rst) ctrl_eff <= '0;
    else     ctrl_eff <= ctrl_s;
  end

  // counter: counting has priority, load only while stopped
  always_ff @(posedge slow_clk) begin
    if (rst)                 cnt <= '0;
    else if (ctrl_eff[CI_EN]) cnt <= cnt + 1'b1;
    else if (arm_s)          cnt <= load_val;
  end

  // snapshot for the bus side: capture on each new request toggle
  always_ff @(posedge slow_clk) begin
    if (rst) begin
      snap_val <= '0;
      snap_ack <= 1'b0;
    end else if (req_s != snap_ack) begin
      snap_val <= cnt;
      snap_ack <= req_s;
    end
  end

  assign match = ctrl_eff[CI_ALM] && (cnt[CNT_W-1:FRAC_W] == alarm_sec);

  always_ff @(posedge slow_clk) begin
    if (rst) begin
      match_q   <= 1'b0;
      match_tgl <= 1'b0;
    end else begin
      match_q <= match;
      if (match && !match_q) match_tgl <= ~match_tgl;
    end
  end

  AST_CNT_STEP: assert property (@(posedge slow_clk) disable iff (rst)
    ctrl_eff[CI_EN] |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
  AST_HOLD_OFF: assert property (@(posedge slow_clk) disable iff (rst)
    (!ctrl_eff[CI_EN] && !arm_s) |=> $stable(cnt)); // R11
  AST_NO_MATCH_OFF: assert property (@(posedge slow_clk) disable iff (rst)
    !ctrl_eff[CI_ALM] |=> $stable(match_tgl)); // R8
endmodule

// File: rtl/rtc_lp_top.sv
module rtc_lp_top
  import rtc_lp_pkg::*;
#(
  parameter int FRAC_W = 15,
  parameter int SEC_W  = 32,
  localparam int CNT_W = FRAC_W + SEC_W,
  localparam int HI_W  = CNT_W - 32
) (
  input  logic              clk_i,
  input  logic              slow_clk_i,
  input  logic              rst_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              alarm_irq_o,
  output logic              wake_o
);
  logic [CTRL_N-1:0] ctrl_q, ctrl_rb, ctrl_eff;
  logic [31:0]       ld_lo, glitch_q;
  logic [HI_W-1:0]   ld_hi;
  logic [SEC_W-1:0]  alarm_q;
  logic              load_arm, flag_q;
  logic              req_q, ack_s, snap_ack;
  logic [CNT_W-1:0]  snap_val, cnt_rb;
  logic              match_tgl, m_s, m_q, alm_evt;
  logic              wr_ctrl, wr_stat, wr_lo, wr_hi;

  assign wr_ctrl = bus_wr_i && bus_addr_i == OFS_CTRL;
  assign wr_stat = bus_wr_i && bus_addr_i == OFS_STAT;
  assign wr_lo   = bus_wr_i && bus_addr_i == OFS_CNTLO;
  assign wr_hi   = bus_wr_i && bus_addr_i == OFS_CNTHI;

  rtc_slow_core #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_core (
    .slow_clk (slow_clk_i),
    .rst      (rst_i),
    .ctrl_req (ctrl_q),
    .load_arm (load_arm),
    .load_val ({ld_hi, ld_lo}),
    .alarm_sec(alarm_q),
    .snap_req (req_q),
    .ctrl_eff (ctrl_eff),
    .snap_val (snap_val),
    .snap_ack (snap_ack),
    .match_tgl(match_tgl)
  );

  rtc_sync #(.W(CTRL_N)) u_rb_sync  (.clk(clk_i), .rst(rst_i), .d(ctrl_eff),  .q(ctrl_rb));
  rtc_sync #(.W(1))      u_ack_sync (.clk(clk_i), .rst(rst_i), .d(snap_ack),  .q(ack_s));
  rtc_sync #(.W(1))      u_mt_sync  (.clk(clk_i), .rst(rst_i), .d(match_tgl), .q(m_s));

  assign alm_evt = m_s ^ m_q;

  // configuration registers
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q   <= '0;
      alarm_q  <= '0;
      glitch_q <= '0;
    end else if (bus_wr_i) begin
      if (wr_ctrl) ctrl_q <= {bus_wdata_i[BIT_WAKE], bus_wdata_i[BIT_ALM], bus_wdata_i[BIT_EN]};
      if (bus_addr_i == OFS_ALARM) alarm_q  <= bus_wdata_i[SEC_W-1:0];
      if (bus_addr_i == OFS_GLTCH) glitch_q <= bus_wdata_i;
    end
  end

  // counter staging, accepted only while the counter is seen stopped
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ld_lo    <= '0;
      ld_hi    <= '0;
      load_arm <= 1'b0;
    end else begin
      if (!ctrl_rb[CI_EN]) begin
        if (wr_lo) ld_lo <= bus_wdata_i;
        if (wr_hi) ld_hi <= bus_wdata_i[HI_W-1:0];
        if (wr_lo || wr_hi) load_arm <= 1'b1;
      end else begin
        load_arm <= 1'b0;
      end
    end
  end

  // snapshot refresh loop
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      req_q  <= 1'b0;
      cnt_rb <= '0;
    end else if (ack_s == req_q) begin
      cnt_rb <= snap_val;
      req_q  <= ~req_q;
    end
  end

  // alarm flag: set by match event, write-one-to-clear
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      m_q    <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      m_q <= m_s;
      if (alm_evt) flag_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[0]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      alarm_irq_o <= 1'b0;
      wake_o      <= 1'b0;
      bus_rdata_o <= '0;
    end else begin
      alarm_irq_o <= flag_q && ctrl_rb[CI_ALM];
      wake_o      <= flag_q && ctrl_rb[CI_WAKE];
      if (bus_rd_i) begin
        case (bus_addr_i)
          OFS_CTRL: begin
            bus_rdata_o           <= '0;
            bus_rdata_o[BIT_EN]   <= ctrl_rb[CI_EN];
            bus_rdata_o[BIT_ALM]  <= ctrl_rb[CI_ALM];
            bus_rdata_o[BIT_WAKE] <= ctrl_rb[CI_WAKE];
          end
          OFS_STAT:  bus_rdata_o <= {31'd0, flag_q};
          OFS_CNTHI: bus_rdata_o <= {{(32-HI_W){1'b0}}, cnt_rb[CNT_W-1:32]};
          OFS_CNTLO: bus_rdata_o <= cnt_rb[31:0];
          OFS_ALARM: bus_rdata_o <= alarm_q;
          OFS_GLTCH: bus_rdata_o <= glitch_q;
          default:   bus_rdata_o <= '0;
        endcase
      end
    end
  end

  AST_FLAG_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(flag_q) |-> $past(alm_evt)); // R6
  AST_W1C: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_stat && bus_wdata_i[0] && !alm_evt) |=> !flag_q); // R7
  AST_LOAD_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
    ctrl_rb[CI_EN] |=> ($stable(ld_lo) && $stable(ld_hi))); // R5
  AST_IRQ_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(alarm_irq_o) |-> $past(ctrl_rb[CI_ALM])); // R9
endmodule

// File: tb/rtc_lp_top_tb_top.sv
module rtc_lp_top_tb_top;
  logic        clk = 1'b0, slow_clk = 1'b0, rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, wake;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] v, v2;

  always #5 clk = ~clk;
  always #80 slow_clk = ~slow_clk;

  rtc_lp_top dut_i (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_i(rst),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .alarm_irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd_reg(8'h04, v); check("R1 ctrl", v, 0);
    rd_reg(8'h18, v); check("R1 status", v, 0);
    rd_reg(8'h1C, v); check("R1 cnt hi", v, 0);
    rd_reg(8'h20, v); check("R1 cnt lo", v, 0);
    rd_reg(8'h24, v); check("R1 alarm", v, 0);
    check("R1 irq/wake", {30'd0, irq, wake}, 0);
  endtask

  task automatic t_glitch;
    wr_reg(8'h30, 32'h41736166); rd_reg(8'h30, v); check("R10 init word", v, 32'h41736166);
    wr_reg(8'h30, 32'hFFFF0000); rd_reg(8'h30, v); check("R10 full word", v, 32'hFFFF0000);
  endtask

  task automatic t_ctrl_sync;
    wr_reg(8'h04, 32'h000000F5);
    rd_reg(8'h04, v); check("R4 readback lags", v, 0);
    wait_slow(8);
    rd_reg(8'h04, v); check("R4 readback settles", v, 32'h1);
    wr_reg(8'h04, 32'h0);
    wait_slow(8);
    rd_reg(8'h04, v); check("R4 disable seen", v, 0);
  endtask

  task automatic t_load;
    wr_reg(8'h20, 32'hDEADBEEF);
    wr_reg(8'h1C, 32'hFFFF1234);
    wait_slow(12);
    rd_reg(8'h20, v); check("R3 lo word", v, 32'hDEADBEEF);
    rd_reg(8'h1C, v); check("R3 hi word", v, 32'h00001234);
  endtask

  task automatic t_count;
    wr_reg(8'h20, 32'h0); wr_reg(8'h1C, 32'h0);
    wait_slow(12);
    wr_reg(8'h04, 32'h1);
    wait_slow(40);
    rd_reg(8'h20, v);
    check("R2 count rate", {31'd0, (v >= 28 && v <= 42)}, 1);
    wr_reg(8'h20, 32'h55);  // R5 ignored while running
    wr_reg(8'h04, 32'h0);
    wait_slow(12);
    rd_reg(8'h20, v);
    wait_slow(10);
    rd_reg(8'h20, v2);
    check("R11 hold when off", v2, v);
    check("R5 write ignored when on", {31'd0, (v >= 40 && v != 32'h55)}, 1);
  endtask

  task automatic t_alarm;
    wr_reg(8'h24, 32'd6);
    wr_reg(8'h20, (32'd5 << 15) | 32'h7FF0); wr_reg(8'h1C, 32'h0);
    wait_slow(12);
    rd_reg(8'h18, v); check("R6 no flag before", v, 0);
    wr_reg(8'h04, 32'h0B);
    wait_slow(40);
    rd_reg(8'h18, v); check("R6 flag set", v, 1);
    check("R9 irq and wake", {30'd0, irq, wake}, 32'h3);
    rd_reg(8'h20, v); check("R2 seconds field", v >> 15, 6);
    wr_reg(8'h04, 32'h09);
    wait_slow(8);
    check("R9 irq off, wake on", {30'd0, irq, wake}, 32'h1);
    wr_reg(8'h18, 32'h0);
    rd_reg(8'h18, v); check("R7 zero write keeps", v, 1);
    wr_reg(8'h18, 32'hFFFFFFFF);
    rd_reg(8'h18, v); check("R7 clear", v, 0);
    @(negedge clk);
    check("R9 wake drops", {31'd0, wake}, 0);
  endtask

  task automatic t_alarm_off;
    wr_reg(8'h04, 32'h0);
    wait_slow(10);
    wr_reg(8'h24, 32'd8);
    wr_reg(8'h20, (32'd7 << 15) | 32'h7FF0); wr_reg(8'h1C, 32'h0);
    wait_slow(12);
    wr_reg(8'h04, 32'h1);
    wait_slow(40);
    rd_reg(8'h18, v); check("R8 no flag when alarm off", v, 0);
    rd_reg(8'h20, v); check("R2 passed alarm second", v >> 15, 8);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (6) @(posedge slow_clk);
    @(negedge clk); rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset;
    t_glitch;
    t_ctrl_sync;
    t_load;
    t_count;
    t_alarm;
    t_alarm_off;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule